// File: doc/BRIEF.md
# Privilege-Filtered Event Counter

This block is a single performance event counter with its own 32-bit configuration word. The word holds a 16-bit event number that picks one line out of a bus of raw event pulses, plus a set of filter bits that decide, for the current privilege level (0 to 3), security state and transactional state, whether a selected pulse may be counted. Whenever the selected line is high and the filters admit the present context, the block raises a count enable, and the 32-bit counter advances by one at the next clock edge.

The filters do not work as one enable bit per level. At secure levels 0 and 1, two suppress bits act directly. At non-secure levels 0 and 1, each level has a companion bit, and counting is allowed when that companion bit equals the matching suppress bit. At level 2, a separate bit enables non-secure counting with the opposite polarity. Secure level 2 counts only when a further bit differs from that enable bit. Level 3 counts when its own bit equals the level-1 suppress bit. Another bit, when set, blocks counting during transactional execution.

Only two windows of event numbers are wired to the bus. The low window starts at 0x0000 and the high window starts at 0x4000. Any other number, and any unsupported number inside either window, counts nothing. The number always reads back exactly as it was written. A single write port loads either the configuration word or the counter value.

Top module: `priv_event_counter`

## Requirements
- R1: A synchronous active-high reset sets the configuration readback, the counter value and the count enable to zero.
- R2: A write with `wr_sel`=0 stores `wr_data` as the configuration word. Bits 25 and 22:16 read back as zero. All other bits, including the event number in bits 15:0, read back exactly as written from the next cycle on.
- R3: A write with `wr_sel`=1 loads `wr_data` into the counter at the clock edge. This load takes priority over an increment in the same cycle.
- R4: In each cycle where `count_en` is high and no counter write occurs, the counter grows by one at the next edge. 0xFFFFFFFF wraps to 0 with no other effect. When `count_en` is low, the value holds.
- R5: An event number k below LO_EVENTS selects `evt_in[k]`. An event number 0x4000+j with j below HI_EVENTS selects `evt_in[LO_EVENTS+j]`. Every other event number never raises `count_en`.
- R6: At level 0, counting in the secure state needs bit 30 clear. In the non-secure state, counting needs bit 28 equal to bit 30.
- R7: At level 1, counting in the secure state needs bit 31 clear. In the non-secure state, counting needs bit 29 equal to bit 31.
- R8: At level 2, counting in the non-secure state needs bit 27 set. In the secure state, counting needs bit 24 to differ from bit 27.
- R9: At level 3, counting needs bit 26 equal to bit 31, whatever the security flag.
- R10: When bit 23 is set and `in_tx` is high, `count_en` is low. When bit 23 is clear, `in_tx` has no effect.
- R11: `count_en` follows the current inputs and the stored configuration in the same cycle. It equals the selected event line ANDed with the context filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 configuration, 1 counter |
| wr_data | input | 32 | Write data |
| evt_in | input | LO_EVENTS+HI_EVENTS | Raw event pulses |
| priv_lvl | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | Secure-state flag |
| in_tx | input | 1 | Transactional-state flag |
| count_en | output | 1 | Selected event admitted this cycle |
| count_value | output | CNT_W | Counter value |
| cfg_rdata | output | 32 | Configuration readback |

## Verification
The hardest part to reach is the full grid of filter settings crossed with every execution context. The equality rules only show their effect when the companion bit and the suppress bit are set to each of their four joint values. The stimulus therefore walks all 256 combinations of the eight filter bits, and under each one it steps through every level, security flag and transactional flag with the selected event held high. Runs with an event number at each window edge, just outside each window, and with a preloaded counter of 0xFFFFFFFF, exercise the selection and wrap boundaries.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int CFG_W = 32;
    localparam int EVNUM_W = 16;
    localparam logic [15:0] HI_WINDOW_BASE = 16'h4000;
    // writable bits: everything except 25 and 22:16
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'hFD80_FFFF;

    typedef enum logic [1:0] {
        PL_USER   = 2'd0,
        PL_KERNEL = 2'd1,
        PL_HYP    = 2'd2,
        PL_MON    = 2'd3
    } priv_lvl_t;

    typedef struct packed {
        logic                 sup_k;      // 31
        logic                 sup_u;      // 30
        logic                 ns_k;       // 29
        logic                 ns_u;       // 28
        logic                 en_hyp;     // 27
        logic                 mon_k;      // 26
        logic                 rsv_mt;     // 25
        logic                 sec_hyp;    // 24
        logic                 tx_block;   // 23
        logic [6:0]           rsv_mid;    // 22:16
        logic [EVNUM_W-1:0]   evnum;      // 15:0
    } evt_cfg_t;

    typedef struct packed {
        priv_lvl_t lvl;
        logic      secure;
        logic      in_tx;
    } exec_ctx_t;

    function automatic evt_cfg_t cfg_sanitize(input logic [CFG_W-1:0] raw);
        evt_cfg_t c;
        c = evt_cfg_t'(raw & CFG_WMASK);
        return c;
    endfunction

    function automatic logic level_admits(input evt_cfg_t c, input exec_ctx_t x);
        logic ok;
        unique case (x.lvl)
            PL_USER:   ok = x.secure ? ~c.sup_u : ~(c.ns_u ^ c.sup_u);
            PL_KERNEL: ok = x.secure ? ~c.sup_k : ~(c.ns_k ^ c.sup_k);
            PL_HYP:    ok = x.secure ? (c.sec_hyp ^ c.en_hyp) : c.en_hyp;
            default:   ok = ~(c.mon_k ^ c.sup_k);
        endcase
        return ok;
    endfunction

    function automatic logic [EVNUM_W-1:0] slot_code(input int slot, input int lo_events);
        logic [EVNUM_W-1:0] code;
        if (slot < lo_events) code = EVNUM_W'(slot);
        else                  code = HI_WINDOW_BASE + EVNUM_W'(slot - lo_events);
        return code;
    endfunction

endpackage

// File: rtl/evc_cfg_reg.sv
module evc_cfg_reg
    import evc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg,
    input  logic [CFG_W-1:0] wr_data,
    output evt_cfg_t         cfg
);

    evt_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= cfg_sanitize(wr_data);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/evc_event_select.sv
module evc_event_select
    import evc_pkg::*;
#(
    parameter int LO_EVENTS = 48,
    parameter int HI_EVENTS = 16,
    localparam int EVT_W = LO_EVENTS + HI_EVENTS
) (
    input  logic [EVNUM_W-1:0] evnum,
    input  logic [EVT_W-1:0]   evt_in,
    output logic               evt_hit
);

    logic [EVT_W-1:0] slot_match;

    for (genvar s = 0; s < EVT_W; s++) begin : g_slot
        localparam logic [EVNUM_W-1:0] CODE = slot_code(s, LO_EVENTS);
        assign slot_match[s] = (evnum == CODE);
    end

    assign evt_hit = |(slot_match & evt_in);

endmodule

// File: rtl/evc_ctx_filter.sv
module evc_ctx_filter
    import evc_pkg::*;
(
    input  evt_cfg_t  cfg,
    input  exec_ctx_t ctx,
    output logic      ctx_pass
);

    logic lvl_ok;
    logic tx_ok;

    always_comb begin
        lvl_ok   = level_admits(cfg, ctx);
        tx_ok    = ~(cfg.tx_block & ctx.in_tx);
        ctx_pass = lvl_ok & tx_ok;
    end

endmodule

// File: rtl/evc_count_reg.sv
module evc_count_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/priv_event_counter.sv
module priv_event_counter
    import evc_pkg::*;
#(
    parameter int LO_EVENTS = 48,
    parameter int HI_EVENTS = 16,
    parameter int CNT_W = 32,
    localparam int EVT_W = LO_EVENTS + HI_EVENTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [EVT_W-1:0] evt_in,
    input  logic [1:0]       priv_lvl,
    input  logic             secure,
    input  logic             in_tx,
    output logic             count_en,
    output logic [CNT_W-1:0] count_value,
    output logic [31:0]      cfg_rdata
);

    evt_cfg_t  cfg;
    exec_ctx_t ctx;
    logic      evt_hit;
    logic      ctx_pass;
    logic      wr_cfg;
    logic      wr_cnt;

    assign wr_cfg = wr_en & ~wr_sel;
    assign wr_cnt = wr_en & wr_sel;
    assign ctx    = '{lvl: priv_lvl_t'(priv_lvl), secure: secure, in_tx: in_tx};

    evc_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_cfg  (wr_cfg),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    evc_event_select #(
        .LO_EVENTS (LO_EVENTS),
        .HI_EVENTS (HI_EVENTS)
    ) u_sel (
        .evnum   (cfg.evnum),
        .evt_in  (evt_in),
        .evt_hit (evt_hit)
    );

    evc_ctx_filter u_flt (
        .cfg      (cfg),
        .ctx      (ctx),
        .ctx_pass (ctx_pass)
    );

    assign count_en = evt_hit & ctx_pass;

    evc_count_reg #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_cnt),
        .load_val (CNT_W'(wr_data)),
        .inc      (count_en),
        .value    (count_value)
    );

    assign cfg_rdata = cfg;

endmodule

// File: rtl/priv_event_counter_chk.sv
module priv_event_counter_chk
    import evc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [31:0]      wr_data,
    input logic [1:0]       priv_lvl,
    input logic             secure,
    input logic             in_tx,
    input logic             count_en,
    input logic [CNT_W-1:0] count_value,
    input logic [31:0]      cfg_rdata
);

    // R2
    cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (cfg_rdata == ($past(wr_data) & CFG_WMASK)));

    // R2
    cfg_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[22:16] == 7'd0) && !cfg_rdata[25]);

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> (count_value == CNT_W'($past(wr_data))));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count_en && !(wr_en && wr_sel)) |=> (count_value == $past(count_value) + CNT_W'(1)));

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !(wr_en && wr_sel)) |=> $stable(count_value));

    // R10
    tx_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[23] && in_tx) |-> !count_en);

    // R7
    sec_kernel_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd1 && secure && cfg_rdata[31]) |-> !count_en);

    // R6
    sec_user_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd0 && secure && cfg_rdata[30]) |-> !count_en);

    // R8
    ns_hyp_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd2 && !secure && !cfg_rdata[27]) |-> !count_en);

    // R9
    mon_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_lvl == 2'd3 && (cfg_rdata[26] != cfg_rdata[31])) |-> !count_en);

endmodule

bind priv_event_counter priv_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .priv_lvl    (priv_lvl),
    .secure      (secure),
    .in_tx       (in_tx),
    .count_en    (count_en),
    .count_value (count_value),
    .cfg_rdata   (cfg_rdata)
);

// File: tb/priv_event_counter_tb.sv
module priv_event_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LO = 48;
    localparam int HI = 16;
    localparam int EW = LO + HI;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [EW-1:0] evt_in = '0;
    logic [1:0]    priv_lvl = '0;
    logic          secure = 1'b0;
    logic          in_tx = 1'b0;
    logic          count_en;
    logic [31:0]   count_value;
    logic [31:0]   cfg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] m_cfg = '0;
    logic [31:0] m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_event_counter #(.LO_EVENTS(LO), .HI_EVENTS(HI), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_in(evt_in), .priv_lvl(priv_lvl), .secure(secure), .in_tx(in_tx),
        .count_en(count_en), .count_value(count_value), .cfg_rdata(cfg_rdata)
    );

    function automatic int slot_of(logic [31:0] c);
        int n = int'(c[15:0]);
        if (n < LO) return n;
        if (n >= 'h4000 && n < 'h4000 + HI) return LO + n - 'h4000;
        return -1;
    endfunction

    function automatic bit ctx_ok(logic [31:0] c, logic [1:0] l, logic s, logic t);
        bit ok;
        case (l)
            2'd0:    ok = s ? !c[30] : (c[28] == c[30]);
            2'd1:    ok = s ? !c[31] : (c[29] == c[31]);
            2'd2:    ok = s ? (c[24] != c[27]) : c[27];
            default: ok = (c[26] == c[31]);
        endcase
        if (c[23] && t) ok = 0;
        return ok;
    endfunction

    function automatic bit model_en(logic [31:0] c, logic [EW-1:0] ev, logic [1:0] l, logic s, logic t);
        int k = slot_of(c);
        if (k < 0) return 0;
        return ev[k] && ctx_ok(c, l, s, t);
    endfunction

    function automatic string en_tag(logic [31:0] c, logic [1:0] l, logic t);
        if (c[23] && t) return "R10";
        if (slot_of(c) < 0) return "R5";
        case (l)
            2'd0:    return "R6";
            2'd1:    return "R7";
            2'd2:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_cfg = '0;
            m_cnt = '0;
        end else begin
            bit e;
            e = model_en(m_cfg, evt_in, priv_lvl, secure, in_tx);
            if (wr_en && wr_sel) m_cnt = wr_data;
            else if (e) m_cnt = m_cnt + 1;
            if (wr_en && !wr_sel) m_cfg = wr_data & 32'hFD80FFFF;
        end
    end

    // per-cycle comparison; R11 same-cycle enable
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({en_tag(m_cfg, priv_lvl, in_tx), "/R11"}, {31'd0, count_en},
                {31'd0, model_en(m_cfg, evt_in, priv_lvl, secure, in_tx)});
            chk("R4", count_value, m_cnt);
            chk("R2", cfg_rdata, m_cfg);
        end
    end

    task automatic drive(logic we, logic ws, logic [31:0] d, logic [EW-1:0] ev,
                         logic [1:0] l, logic s, logic t);
        @(negedge clk);
        #1;
        wr_en = we; wr_sel = ws; wr_data = d; evt_in = ev;
        priv_lvl = l; secure = s; in_tx = t;
    endtask

    task automatic wr_cfg(logic [31:0] d);
        drive(1'b1, 1'b0, d, '0, 2'd0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", count_value, 32'd0);
        chk("R1", cfg_rdata, 32'd0);
        chk("R1", {31'd0, count_en}, 32'd0);
        #1 rst = 1'b0;

        // R2 reserved bits masked, event number kept
        wr_cfg(32'hFFFF_FFFF);
        drive(1'b0, 1'b0, '0, '0, 2'd0, 1'b1, 1'b0);
        chk("R2", cfg_rdata, 32'hFD80_FFFF);

        // R6..R10: every filter-bit combination over every context
        for (int f = 0; f < 256; f++) begin
            logic [31:0] c;
            c = {f[7:2], 1'b0, f[1:0], 7'd0, 16'd5};
            wr_cfg(c);
            for (int x = 0; x < 16; x++)
                drive(1'b0, 1'b0, '0, {EW{1'b1}}, x[1:0], x[2], x[3]);
        end

        // R5 window edges and outside values
        begin
            logic [15:0] nums [10] = '{16'h0000, 16'h002F, 16'h0030, 16'h003F, 16'h4000,
                                       16'h400F, 16'h4010, 16'h403F, 16'h0100, 16'h8000};
            foreach (nums[i]) begin
                wr_cfg({16'd0, nums[i]});
                for (int r = 0; r < 12; r++)
                    drive(1'b0, 1'b0, '0, {$urandom, $urandom}, 2'd0, 1'b1, 1'b0);
                drive(1'b0, 1'b0, '0, {EW{1'b1}}, 2'd0, 1'b1, 1'b0);
            end
        end
        for (int r = 0; r < 300; r++) begin
            if (r % 20 == 0) wr_cfg({16'd0, ($urandom % 2) ? 16'h4000 + 16'($urandom % 20) : 16'($urandom % 52)});
            drive(1'b0, 1'b0, '0, {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom));
        end

        // R3 load beats a simultaneous increment; R4 wrap
        wr_cfg(32'h0000_0003);
        drive(1'b1, 1'b1, 32'hFFFF_FFFF, {EW{1'b1}}, 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R3", count_value, 32'hFFFF_FFFF);
        #1 wr_en = 1'b0;
        @(negedge clk);
        chk("R4", count_value, 32'd0);
        drive(1'b0, 1'b0, '0, '0, 2'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4", count_value, 32'd1);

        // R1 reset mid-run
        #1 rst = 1'b1;
        @(negedge clk);
        chk("R1", count_value, 32'd0);
        chk("R1", cfg_rdata, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule